// File: doc/BRIEF.md
# Interrupt Cause and Mask Controller

This block gathers interrupt causes for a network controller and drives a single level-sensitive interrupt line. Event pulses from the receive path, the transmit path, the link logic and the management interface set bits in a cause register. Software reads and clears that register, can inject causes through a set-only alias, and chooses which causes may raise the line through an enable mask that has separate set and clear write ports.

A small register bus, one access per strobe, provides the side effects. A read of the cause register returns its value and empties it. A write to the cause register clears every bit written as 1. Bit 31 is a summary flag. It is on whenever any cause is pending, so a single bit test tells software that something is set.

Top module: `irq_cause_ctl`

## Requirements
- R1: Bit 31 of the stored cause is 1 whenever the stored cause is nonzero. A zero cause has bit 31 at 0.
- R2: A write to word address 1 (cause-set alias) ORs the written data into the cause register.
- R3: A read of word address 1 returns the same value as the cause register and leaves the causes unchanged.
- R4: A read of word address 0 (cause) returns the current cause value. On the following clock edge the whole register becomes zero, summary bit included. A one-cycle read strobe clears it exactly once.
- R5: A write to word address 0 clears each cause bit written as 1 and keeps the others. If any cause bit remains, bit 31 stays set even when bit 31 was written as 1.
- R6: A write to word address 2 ORs the data into the enable mask. A write to word address 3 clears the mask bits written as 1. A read of address 2 returns the mask, and a read of address 3 returns zero.
- R7: `irq_o` is high exactly when the bitwise AND of mask and cause is nonzero. It follows each register update in the same cycle.
- R8: A hardware event bit that arrives in the same cycle as a cause read or a write-1-to-clear of that bit is kept in the cause register.
- R9: Reset clears the cause and the mask, so `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_i | input | 32 | Single-cycle hardware event pulses, one bit per cause |
| bus_addr_i | input | 2 | Word address of the register access |
| bus_wr_i | input | 1 | One-cycle write strobe |
| bus_rd_i | input | 1 | One-cycle read strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid while the read strobe is high |
| irq_o | output | 1 | Level interrupt output |

## Verification
The assertions check these rules on every cycle: the summary flag against the other cause bits, set-alias writes landing in the cause, write-1-to-clear and read-to-clear results, mask set and clear effects, event bits that must survive, and the interrupt line never rising on an empty cause. The bench scenarios cover the rest. They show that read data carries the value from before the clear, that the alias read does not clear, and that every cause bit can be routed individually to the line. They also exercise the exact collisions of events with reads and clears, and the reset state.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

   // decoded register accesses for one bus cycle
   typedef struct packed {
      logic rd_cause;   // read of cause register (clears it)
      logic wr_cause;   // write-1-to-clear on cause
      logic wr_cset;    // OR into cause through the alias
      logic wr_mset;    // OR into enable mask
      logic wr_mclr;    // clear bits of enable mask
      logic rd_mask;    // read returns the mask
      logic rd_calias;  // read returns the cause, no side effect
   } irq_acc_t;

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
   import irq_ctl_pkg::*;
#(
   parameter int ADDR_W     = 2,
   parameter int OFS_CAUSE  = 0,
   parameter int OFS_CSET   = 1,
   parameter int OFS_MSET   = 2,
   parameter int OFS_MCLR   = 3
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_i,
   input  logic              rd_i,
   output irq_acc_t          acc_o
);

   localparam int N_WORDS = 1 << ADDR_W;

   if (OFS_CAUSE >= N_WORDS || OFS_CSET >= N_WORDS ||
       OFS_MSET >= N_WORDS || OFS_MCLR >= N_WORDS) begin : g_bad_ofs
      $error("irq_reg_decode: offset outside address space");
   end
   if (OFS_CAUSE == OFS_CSET || OFS_CAUSE == OFS_MSET || OFS_CAUSE == OFS_MCLR ||
       OFS_CSET == OFS_MSET || OFS_CSET == OFS_MCLR ||
       OFS_MSET == OFS_MCLR) begin : g_bad_overlap
      $error("irq_reg_decode: register offsets must be distinct");
   end

   localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(OFS_CAUSE);
   localparam logic [ADDR_W-1:0] A_CSET  = ADDR_W'(OFS_CSET);
   localparam logic [ADDR_W-1:0] A_MSET  = ADDR_W'(OFS_MSET);
   localparam logic [ADDR_W-1:0] A_MCLR  = ADDR_W'(OFS_MCLR);

   always_comb begin
      acc_o           = '0;
      acc_o.rd_cause  = rd_i && (addr_i == A_CAUSE);
      acc_o.rd_calias = rd_i && (addr_i == A_CSET);
      acc_o.rd_mask   = rd_i && (addr_i == A_MSET);
      acc_o.wr_cause  = wr_i && (addr_i == A_CAUSE);
      acc_o.wr_cset   = wr_i && (addr_i == A_CSET);
      acc_o.wr_mset   = wr_i && (addr_i == A_MSET);
      acc_o.wr_mclr   = wr_i && (addr_i == A_MCLR);
   end

   // at most one register is selected per access
   always_comb begin
      if (!$isunknown(addr_i))
         a_r6_one_target: assert ($onehot0({acc_o.wr_cause, acc_o.wr_cset,
                                            acc_o.wr_mset, acc_o.wr_mclr}));
   end

endmodule

// File: rtl/irq_cause_reg.sv
module irq_cause_reg #(
   parameter int DATA_W  = 32,
   parameter int SUM_BIT = DATA_W - 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [DATA_W-1:0] evt_i,
   input  logic              clr_all_i,
   input  logic              w1c_i,
   input  logic              set_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] cause_o
);

   if (DATA_W < 2) begin : g_bad_w
      $error("irq_cause_reg: DATA_W must be at least 2");
   end
   if (SUM_BIT < 0 || SUM_BIT >= DATA_W) begin : g_bad_sum
      $error("irq_cause_reg: SUM_BIT out of range");
   end

   localparam logic [DATA_W-1:0] SUM_MASK = DATA_W'(1) << SUM_BIT;

   logic [DATA_W-1:0] cause_q;
   logic [DATA_W-1:0] raw_nx;
   logic [DATA_W-1:0] cause_nx;

   // per-bit update: clear-on-read, then write-1-to-clear, then set, then events
   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      logic keep_b;
      always_comb begin
         keep_b    = cause_q[b] && !clr_all_i && !(w1c_i && wdata_i[b]);
         raw_nx[b] = keep_b || (set_i && wdata_i[b]) || evt_i[b];
      end
   end

   // summary flag follows any pending cause
   always_comb begin
      cause_nx = raw_nx;
      if (raw_nx != '0)
         cause_nx = raw_nx | SUM_MASK;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cause_q <= '0;
      else         cause_q <= cause_nx;
   end

   assign cause_o = cause_q;

   a_r1_summary_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cause_q != '0) |-> cause_q[SUM_BIT]);

   a_r2_set_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i |=> ((cause_q & $past(wdata_i)) == $past(wdata_i)));

   a_r4_read_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_all_i && !set_i && evt_i == '0) |=> (cause_q == '0));

   a_r5_w1c_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (w1c_i && !set_i && evt_i == '0) |=>
         ((cause_q & $past(wdata_i) & ~SUM_MASK) == '0));

   a_r8_event_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_i != '0) |=> ((cause_q & $past(evt_i)) == $past(evt_i)));

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
   parameter int DATA_W = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              set_i,
   input  logic              clr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] mask_o
);

   logic [DATA_W-1:0] mask_q;
   logic [DATA_W-1:0] mask_nx;

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      always_comb begin
         mask_nx[b] = (mask_q[b] || (set_i && wdata_i[b])) && !(clr_i && wdata_i[b]);
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mask_q <= '0;
      else         mask_q <= mask_nx;
   end

   assign mask_o = mask_q;

   a_r6_mask_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_i && !clr_i) |=> ((mask_q & $past(wdata_i)) == $past(wdata_i)));

   a_r6_mask_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> ((mask_q & $past(wdata_i)) == '0));

   a_r6_mask_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!set_i && !clr_i) |=> $stable(mask_q));

endmodule

// File: rtl/irq_cause_ctl.sv
module irq_cause_ctl
   import irq_ctl_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 2,
   parameter int SUM_BIT   = DATA_W - 1,
   parameter int OFS_CAUSE = 0,
   parameter int OFS_CSET  = 1,
   parameter int OFS_MSET  = 2,
   parameter int OFS_MCLR  = 3
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [DATA_W-1:0] evt_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic              bus_wr_i,
   input  logic              bus_rd_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic              irq_o
);

   if (ADDR_W < 2) begin : g_bad_aw
      $error("irq_cause_ctl: four registers need ADDR_W >= 2");
   end

   irq_acc_t          acc;
   logic [DATA_W-1:0] cause;
   logic [DATA_W-1:0] mask;
   logic [DATA_W-1:0] pend;

   irq_reg_decode #(
      .ADDR_W    (ADDR_W),
      .OFS_CAUSE (OFS_CAUSE),
      .OFS_CSET  (OFS_CSET),
      .OFS_MSET  (OFS_MSET),
      .OFS_MCLR  (OFS_MCLR)
   ) dec_i (
      .addr_i (bus_addr_i),
      .wr_i   (bus_wr_i),
      .rd_i   (bus_rd_i),
      .acc_o  (acc)
   );

   irq_cause_reg #(
      .DATA_W  (DATA_W),
      .SUM_BIT (SUM_BIT)
   ) cause_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .evt_i     (evt_i),
      .clr_all_i (acc.rd_cause),
      .w1c_i     (acc.wr_cause),
      .set_i     (acc.wr_cset),
      .wdata_i   (bus_wdata_i),
      .cause_o   (cause)
   );

   irq_mask_reg #(
      .DATA_W (DATA_W)
   ) mask_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_i   (acc.wr_mset),
      .clr_i   (acc.wr_mclr),
      .wdata_i (bus_wdata_i),
      .mask_o  (mask)
   );

   // read mux: cause and alias show the same value, mask-clear reads zero
   always_comb begin
      bus_rdata_o = '0;
      if (acc.rd_cause || acc.rd_calias) bus_rdata_o = cause;
      else if (acc.rd_mask)              bus_rdata_o = mask;
   end

   assign pend  = cause & mask;
   assign irq_o = |pend;

   a_r7_irq_needs_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> (cause != '0) && (mask != '0));

   a_r3_alias_no_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (acc.rd_calias && evt_i == '0) |=> (cause == $past(cause)));

   a_r9_quiet_after_reset: assert property (@(posedge clk_i)
      $rose(rst_ni) |-> !irq_o);

endmodule

// File: tb/irq_cause_ctl_tb_top.sv
`timescale 1ns/1ps
module irq_cause_ctl_tb_top;

   localparam logic [31:0] SUM = 32'h8000_0000;
   localparam logic [1:0]  A_CAUSE = 2'd0, A_CSET = 2'd1, A_MSET = 2'd2, A_MCLR = 2'd3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] evt = '0;
   logic [1:0]  addr = '0;
   logic        wr = 1'b0, rd = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;

   int n_chk = 0;
   int n_fail = 0;
   logic [31:0] m_cause = '0;
   logic [31:0] m_mask = '0;
   logic [31:0] got;

   always #2.5 clk = ~clk;

   irq_cause_ctl dut_i (
      .clk_i (clk), .rst_ni (rst_n), .evt_i (evt), .bus_addr_i (addr),
      .bus_wr_i (wr), .bus_rd_i (rd), .bus_wdata_i (wdata),
      .bus_rdata_o (rdata), .irq_o (irq)
   );

   function automatic logic [31:0] with_sum(input logic [31:0] v);
      return (v == 0) ? 32'h0 : (v | SUM);
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // one bus cycle plus optional events; model updated from the requirements
   task automatic cyc(input string tag, input bit w, input bit r, input logic [1:0] a,
                      input logic [31:0] wd, input logic [31:0] ev);
      logic [31:0] exp_rd;
      logic [31:0] c;
      @(negedge clk);
      wr = w; rd = r; addr = a; wdata = wd; evt = ev;
      #1;
      exp_rd = (a == A_CAUSE || a == A_CSET) ? m_cause : (a == A_MSET) ? m_mask : 32'h0;
      if (r) chk(tag, rdata, exp_rd);
      c = m_cause;
      if (r && a == A_CAUSE) c = 0;
      if (w && a == A_CAUSE) c = c & ~wd;
      if (w && a == A_CSET)  c = c | wd;
      c = with_sum(c | ev);
      m_cause = c;
      if (w && a == A_MSET) m_mask = m_mask | wd;
      if (w && a == A_MCLR) m_mask = m_mask & ~wd;
      @(negedge clk);
      wr = 0; rd = 0; evt = '0; wdata = '0;
      #0.5;
      chk({tag, " R7 irq"}, {31'h0, irq}, {31'h0, (m_cause & m_mask) != 0});
   endtask

   task automatic peek(input string tag);
      cyc(tag, 0, 1, A_CSET, 0, 0);
   endtask

   initial begin
      #(200000 * 5);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #0.5;
      chk("R9 irq after reset", {31'h0, irq}, 32'h0);
      rst_n = 1'b1;
      peek("R9 cause after reset");
      cyc("R9 mask after reset", 0, 1, A_MSET, 0, 0);

      // every event bit, read back, cleared by read
      for (int i = 0; i < 32; i++) begin
         cyc("R8 event only", 0, 0, A_CAUSE, 0, 32'h1 << i);
         peek("R1 R3 alias shows event with summary");
         cyc("R4 read returns cause", 0, 1, A_CAUSE, 0, 0);
         peek("R4 cause empty after read");
      end

      // alias sets
      cyc("R2 set low bits", 1, 0, A_CSET, 32'h5, 0);
      cyc("R2 set more", 1, 0, A_CSET, 32'hA0, 0);
      peek("R2 R1 or-ed value");
      peek("R3 alias read twice unchanged");
      // write-1-to-clear
      cyc("R5 clear low", 1, 0, A_CAUSE, 32'h5, 0);
      peek("R5 remainder keeps summary");
      cyc("R5 clear summary only", 1, 0, A_CAUSE, SUM, 0);
      peek("R5 R1 summary reasserted");
      cyc("R5 clear rest", 1, 0, A_CAUSE, 32'hFFFF_FFFF, 0);
      peek("R5 R1 all clear");
      cyc("R2 set summary alone", 1, 0, A_CSET, SUM, 0);
      peek("R2 summary alone");
      cyc("R4 clear by read", 0, 1, A_CAUSE, 0, 0);

      // per-bit masking
      for (int i = 0; i < 31; i++) begin
         cyc("R6 mask set", 1, 0, A_MSET, 32'h1 << i, 0);
         cyc("R6 mask read", 0, 1, A_MSET, 0, 0);
         cyc("R7 other cause", 1, 0, A_CSET, 32'h1 << ((i + 1) % 31), 0);
         cyc("R7 matching cause", 1, 0, A_CSET, 32'h1 << i, 0);
         cyc("R6 mask clear", 1, 0, A_MCLR, 32'h1 << i, 0);
         cyc("R6 mask-clear reads zero", 0, 1, A_MCLR, 0, 0);
         cyc("R4 drain", 0, 1, A_CAUSE, 0, 0);
      end
      cyc("R6 summary mask", 1, 0, A_MSET, SUM, 0);
      cyc("R7 summary routes", 0, 0, A_CAUSE, 0, 32'h40);
      cyc("R6 clear all", 1, 0, A_MCLR, 32'hFFFF_FFFF, 0);
      cyc("R4 drain", 0, 1, A_CAUSE, 0, 0);

      // collisions
      cyc("R2 preset", 1, 0, A_CSET, 32'h3, 0);
      cyc("R8 event during read", 0, 1, A_CAUSE, 0, 32'h100);
      peek("R8 event survives read");
      cyc("R8 event during w1c", 1, 0, A_CAUSE, 32'h100, 32'h100);
      peek("R8 event survives w1c");
      cyc("R4 single clear", 0, 1, A_CAUSE, 0, 0);
      cyc("R4 second read empty", 0, 1, A_CAUSE, 0, 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule